// File: doc/BRIEF.md
# Multiplexed External Bus Master

This block turns single read or write requests from an on-chip requester into cycles on an external parallel bus. A request carries an address, write data, an access size (byte, 16-bit or 32-bit) and a direction flag. The block compares the address against six configurable address windows, picks the chip select of the first window that matches, and runs one cycle. That cycle has a one-clock address phase followed by a data phase. The data phase lasts until the external device pulls the acknowledge input low. Read data comes back right-justified on the response port one clock after the acknowledge.

Each chip select has a port width of 32, 16 or 8 bits. Data always travels on the most significant byte lanes that the port width allows. A mode input picks one of two bus layouts. In separate mode, dedicated address pins carry the address while the data pins carry only data. In shared mode, the data pins carry the full address during the address phase. During the data phase they then carry data on the data lanes, and the low address bits stay on the lanes that carry no data. A request that matches no window, or that is wider than the selected port, gets an error response at once, and no bus cycle starts.

Top module: `extbus_master`

## Requirements
- R1: While reset is held, and whenever no cycle is running, the outputs are: all chip selects high, tsN high, ale low, oeN high, rdWr high, tbstN high, beN all high, busDOe zero, tsiz 00 and busy low.
- R2: During a whole cycle, rdWr is 1 for a read and 0 for a write. oeN goes low only during the data phase of a read.
- R3: Window i matches when (reqAddr & mask_i) == base_i. The lowest matching index wins. Exactly that chip select is driven low, from the address phase until the acknowledge.
- R4: tsN is low for exactly one clock, the address phase, which is the clock after the request is accepted. ale is always the inverse of tsN.
- R5: tsiz is 01 for a byte, 10 for 16 bits and 00 for 32 bits during the cycle. tbstN stays high.
- R6: If reqSize is 3, if no window matches, or if the size is wider than the selected port (16 bits on an 8-bit port, 32 bits on a 16-bit or 8-bit port), then no chip select or tsN goes low. rspValid and rspErr are high for the one clock after the request.
- R7: In shared mode (muxMode=1), busDOut carries the full 32-bit address during the address phase, with all four busDOe lane enables set.
- R8: In the shared-mode data phase, a 32-bit port uses lanes 3..0 for data. A 16-bit port uses lanes 3..2 for data and keeps address[15:0] on bits [15:0]. An 8-bit port uses lane 3 for data and keeps address[23:0] on bits [23:0]. Address lanes stay enabled; data lanes are enabled only for writes. Lane k is bits [8k+7:8k].
- R9: In separate mode (muxMode=0), busAddr holds the address through the whole cycle. Data lanes are enabled only for writes, from the address phase on, and the other lanes are disabled.
- R10: The data phase lasts until taN is sampled low at a rising edge. rspValid (with rspErr low) is then high for the next clock. busy is high from the address phase until the acknowledge.
- R11: Byte lanes follow big-endian order inside the port. For a byte access, offset = address modulo the port bytes, and the lane is 3 minus the offset. For a 16-bit access, the lane pair is 3..2 on an offset-0 half and 1..0 on an offset-2 half of a 32-bit port. beN is low on exactly those lanes. Write data is replicated across all lanes (a byte four times, a half twice). Read data is taken from those lanes and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| muxMode | input | 1 | 1 = shared address/data pins, 0 = separate address pins |
| reqValid | input | 1 | Request present; accepted when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| reqAddr | input | 32 | Request address |
| reqWData | input | 32 | Write data, right-justified |
| busy | output | 1 | A bus cycle is running |
| rspValid | output | 1 | Response strobe, one clock |
| rspErr | output | 1 | Response is an error |
| rspRData | output | 32 | Read data, right-justified |
| busAddr | output | 32 | Address pins (separate mode) |
| busDOut | output | 32 | Data or address/data pins, driven value |
| busDOe | output | 4 | Per-lane drive enable of busDOut |
| busDIn | input | 32 | Data pins, sampled value |
| csN | output | NUM_CS (6) | Chip selects, active low |
| beN | output | 4 | Byte enables, active low, bit k = lane k |
| oeN | output | 1 | Output enable, active low |
| rdWr | output | 1 | 1 read, 0 write |
| tsN | output | 1 | Transfer start, active low |
| ale | output | 1 | Address latch enable, inverse of tsN |
| tsiz | output | 2 | Transfer size code |
| tbstN | output | 1 | Burst indicator, active low, held high |
| taN | input | 1 | Transfer acknowledge, active low |

## Verification
The bench checks every pin of the cycle at each clock. A state register that is one step off makes tsN stay low a second clock, makes the chip select drop late, or makes busy and the chip select release before or after the clock that follows the acknowledge. A wrong latched port width or address shows in the next data phase: data lands on the wrong lanes, address bits are lost from the non-data lanes, and beN or the right-justified read data differ. A decode or size-check fault shows as a bus cycle where an error response was due, or the reverse, within one clock of the request.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] PW_32 = 2'd0;
  localparam logic [1:0] PW_16 = 2'd1;
  localparam logic [1:0] PW_8  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} state_e;

  typedef struct packed {
    logic load;
    logic addrPh;
    logic dataPh;
    logic capture;
  } ctrl_t;

  function automatic logic [LANES-1:0] dataLaneMask(input logic [1:0] pw);
    case (pw)
      PW_16:   return 4'b1100;
      PW_8:    return 4'b1000;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/extbus_csdec.sv
module extbus_csdec #(
  parameter int NUM_CS = 6,
  parameter int AW = 32,
  parameter logic [NUM_CS*AW-1:0] CS_BASE = '0,
  parameter logic [NUM_CS*AW-1:0] CS_MASK = '0,
  parameter logic [NUM_CS*2-1:0]  CS_PW   = '0
) (
  input  logic [AW-1:0]     addr,
  output logic              hit,
  output logic [NUM_CS-1:0] csSel,
  output logic [1:0]        pw
);
  logic [NUM_CS-1:0] rawHit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign rawHit[g] = ((addr & CS_MASK[g*AW +: AW]) == CS_BASE[g*AW +: AW]);
  end

  assign hit = |rawHit;

  always_comb begin
    csSel = '0;
    pw    = CS_PW[1:0];
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (rawHit[i]) begin
        csSel    = '0;
        csSel[i] = 1'b1;
        pw       = CS_PW[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic       hit,
  input  logic [1:0] pw,
  input  logic       taN,
  output ctrl_t      ctl,
  output logic       busy,
  output logic       rspValid,
  output logic       rspErr
);
  state_e state;
  logic   sizeOk;

  always_comb begin
    case (reqSize)
      SZ_BYTE: sizeOk = 1'b1;
      SZ_HALF: sizeOk = (pw != PW_8);
      SZ_WORD: sizeOk = (pw == PW_32);
      default: sizeOk = 1'b0;
    endcase
  end

  always_comb begin
    ctl.load    = (state == ST_IDLE) && reqValid && hit && sizeOk;
    ctl.addrPh  = (state == ST_ADDR);
    ctl.dataPh  = (state == ST_DATA);
    ctl.capture = (state == ST_DATA) && !taN;
  end

  assign busy = ctl.addrPh || ctl.dataPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctl.load) begin
            state <= ST_ADDR;
          end else if (reqValid) begin
            rspValid <= 1'b1;
            rspErr   <= 1'b1;
          end
        end
        ST_ADDR: state <= ST_DATA;
        ST_DATA: begin
          if (!taN) begin
            state    <= ST_IDLE;
            rspValid <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: the address phase never lasts two clocks
  a_r4_ts_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrPh |=> (!ctl.addrPh && ctl.dataPh));

  // R10: a good response only follows an acknowledged data phase
  a_r10_rsp_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> ($past(!taN) && $past(ctl.dataPh)));

  // R6: an error response only follows a refused request in idle
  a_r6_err_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> ($past(reqValid) && !$past(busy)));
endmodule

// File: rtl/extbus_dp.sv
module extbus_dp
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic              muxMode,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWData,
  input  logic [NUM_CS-1:0] csSel,
  input  logic [1:0]        pw,
  input  logic [BUS_W-1:0]  busDIn,
  output logic [BUS_W-1:0]  rspRData,
  output logic [BUS_W-1:0]  busAddr,
  output logic [BUS_W-1:0]  busDOut,
  output logic [LANES-1:0]  busDOe,
  output logic [NUM_CS-1:0] csN,
  output logic [LANES-1:0]  beN,
  output logic              oeN,
  output logic              rdWr,
  output logic              tsN,
  output logic              ale,
  output logic [1:0]        tsiz,
  output logic              tbstN
);
  logic [BUS_W-1:0]  addrQ, wdataQ, wLanes;
  logic [1:0]        sizeQ, pwQ, off;
  logic              writeQ, active;
  logic [NUM_CS-1:0] csQ;
  logic [LANES-1:0]  dLanes, selLanes;
  logic [BUS_W-1:0]  rdExt;
  int                laneIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; wdataQ <= '0; sizeQ <= SZ_BYTE; pwQ <= PW_32;
      writeQ <= 1'b0; csQ <= '0; rspRData <= '0;
    end else begin
      if (ctl.load) begin
        addrQ <= reqAddr; wdataQ <= reqWData; sizeQ <= reqSize;
        pwQ <= pw; writeQ <= reqWrite; csQ <= csSel;
      end
      if (ctl.capture) rspRData <= rdExt;
    end
  end

  assign active = ctl.addrPh || ctl.dataPh;
  assign dLanes = dataLaneMask(pwQ);

  always_comb begin
    case (pwQ)
      PW_32:   off = addrQ[1:0];
      PW_16:   off = {1'b0, addrQ[0]};
      default: off = 2'd0;
    endcase
    laneIdx = 3 - int'(off);
    case (sizeQ)
      SZ_BYTE: begin
        wLanes   = {LANES{wdataQ[7:0]}};
        selLanes = 4'b1000 >> off;
        rdExt    = {24'd0, busDIn[8*laneIdx +: 8]};
      end
      SZ_HALF: begin
        wLanes   = {2{wdataQ[15:0]}};
        selLanes = off[1] ? 4'b0011 : 4'b1100;
        rdExt    = off[1] ? {16'd0, busDIn[15:0]} : {16'd0, busDIn[31:16]};
      end
      default: begin
        wLanes   = wdataQ;
        selLanes = 4'b1111;
        rdExt    = busDIn;
      end
    endcase
  end

  always_comb begin
    busDOut = '0;
    busDOe  = '0;
    if (active) begin
      if (muxMode && ctl.addrPh) begin
        busDOut = addrQ;
        busDOe  = '1;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (dLanes[l]) begin
            busDOut[8*l +: 8] = writeQ ? wLanes[8*l +: 8] : 8'd0;
            busDOe[l]         = writeQ;
          end else if (muxMode) begin
            busDOut[8*l +: 8] = addrQ[8*l +: 8];
            busDOe[l]         = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (sizeQ)
      SZ_BYTE: tsiz = 2'b01;
      SZ_HALF: tsiz = 2'b10;
      default: tsiz = 2'b00;
    endcase
    if (!active) tsiz = 2'b00;
  end

  assign busAddr = (active && !muxMode) ? addrQ : '0;
  assign csN     = active ? ~csQ : '1;
  assign beN     = active ? ~selLanes : '1;
  assign oeN     = !(ctl.dataPh && !writeQ);
  assign rdWr    = active ? !writeQ : 1'b1;
  assign tsN     = !ctl.addrPh;
  assign ale     = ctl.addrPh;
  assign tbstN   = 1'b1;

  // R3: never more than one chip select low
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R2: output enable only during reads
  a_r2_oe_read_only: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> rdWr);

  // R8: 8-bit port in shared mode keeps the low address bits steady into the data phase
  a_r8_addr_lanes_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dataPh && muxMode && $stable(muxMode) && pwQ == PW_8)
      |-> busDOut[23:0] == $past(busDOut[23:0]));
endmodule

// File: rtl/extbus_master.sv
module extbus_master
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter logic [NUM_CS*BUS_W-1:0] CS_BASE = {32'h2000_0000, 32'h5000_0000, 32'h4000_0000,
                                                32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_CS*BUS_W-1:0] CS_MASK = {32'hE000_0000, 32'hF000_0000, 32'hF000_0000,
                                                32'hF000_0000, 32'hF000_0000, 32'hF000_0000},
  parameter logic [NUM_CS*2-1:0]     CS_PW   = {2'd1, 2'd1, 2'd0, 2'd2, 2'd1, 2'd0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              muxMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqAddr,
  input  logic [31:0]       reqWData,
  output logic              busy,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRData,
  output logic [31:0]       busAddr,
  output logic [31:0]       busDOut,
  output logic [3:0]        busDOe,
  input  logic [31:0]       busDIn,
  output logic [NUM_CS-1:0] csN,
  output logic [3:0]        beN,
  output logic              oeN,
  output logic              rdWr,
  output logic              tsN,
  output logic              ale,
  output logic [1:0]        tsiz,
  output logic              tbstN,
  input  logic              taN
);
  ctrl_t             ctl;
  logic              hit;
  logic [NUM_CS-1:0] csSel;
  logic [1:0]        pw;

  extbus_csdec #(.NUM_CS(NUM_CS), .AW(BUS_W), .CS_BASE(CS_BASE),
                 .CS_MASK(CS_MASK), .CS_PW(CS_PW)) u_dec (
    .addr(reqAddr), .hit(hit), .csSel(csSel), .pw(pw));

  extbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
    .hit(hit), .pw(pw), .taN(taN), .ctl(ctl), .busy(busy),
    .rspValid(rspValid), .rspErr(rspErr));

  extbus_dp #(.NUM_CS(NUM_CS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .muxMode(muxMode),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWData(reqWData), .csSel(csSel), .pw(pw), .busDIn(busDIn),
    .rspRData(rspRData), .busAddr(busAddr), .busDOut(busDOut),
    .busDOe(busDOe), .csN(csN), .beN(beN), .oeN(oeN), .rdWr(rdWr),
    .tsN(tsN), .ale(ale), .tsiz(tsiz), .tbstN(tbstN));

  // R6: a refused request leaves every chip select high
  a_r6_err_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (&csN));
endmodule

// File: tb/tb_extbus_master.sv
module tb_extbus_master;
  logic        clk = 1'b0;
  logic        rstN, muxMode, reqValid, reqWrite, taN;
  logic [1:0]  reqSize;
  logic [31:0] reqAddr, reqWData, busDIn;
  logic        busy, rspValid, rspErr, oeN, rdWr, tsN, ale, tbstN;
  logic [31:0] rspRData, busAddr, busDOut;
  logic [3:0]  busDOe, beN;
  logic [5:0]  csN;
  logic [1:0]  tsiz;

  always #5 clk = ~clk;

  extbus_master dut (.*);

  int checks = 0, errors = 0;
  typedef struct { logic err; logic [31:0] data; } rsp_t;
  rsp_t expQ[$];
  rsp_t got;

  // window table of the default configuration: base, mask, port bytes
  logic [31:0] wBase [6] = '{32'h0000_0000, 32'h1000_0000, 32'h2000_0000,
                             32'h4000_0000, 32'h5000_0000, 32'h2000_0000};
  logic [31:0] wMask [6] = '{32'hF000_0000, 32'hF000_0000, 32'hF000_0000,
                             32'hF000_0000, 32'hF000_0000, 32'hE000_0000};
  int          wBytes[6] = '{4, 2, 1, 4, 2, 2};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) check("R10 unexpected response", 32'd1, 32'd0);
      else begin
        got = expQ.pop_front();
        check("R6 rspErr", {31'd0, rspErr}, {31'd0, got.err});
        if (!got.err) check("R11 rspRData", rspRData, got.data);
      end
    end
  end

  function automatic int findWin(logic [31:0] a);
    for (int i = 0; i < 6; i++) if ((a & wMask[i]) == wBase[i]) return i;
    return -1;
  endfunction

  task automatic txn(bit mux, bit wr, logic [1:0] sz, logic [31:0] a,
                     logic [31:0] wd, logic [31:0] rd, int waits);
    int win, nb, off, topLane;
    bit bad;
    logic [3:0] dl, sel, expOe;
    logic [31:0] rep, expOut, lm, rdExp;
    win = findWin(a);
    nb  = (win >= 0) ? wBytes[win] : 4;
    bad = (win < 0) || (sz == 2'd3) || (sz == 2'd1 && nb < 2) || (sz == 2'd2 && nb < 4);
    off = int'(a % nb);
    dl  = '0;
    for (int l = 0; l < 4; l++) dl[l] = (l >= 4 - nb);
    if (sz == 2'd0) begin
      sel = '0; sel[3-off] = 1'b1; rep = {4{wd[7:0]}};
      rdExp = (rd >> (8*(3-off))) & 32'hFF;
    end else if (sz == 2'd1) begin
      off = off & 2; topLane = 3 - off;
      sel = '0; sel[topLane] = 1'b1; sel[topLane-1] = 1'b1; rep = {2{wd[15:0]}};
      rdExp = (rd >> (8*(2-off))) & 32'hFFFF;
    end else begin
      sel = 4'hF; rep = wd; rdExp = rd;
    end
    expQ.push_back('{bad, wr ? 32'd0 : rdExp});
    muxMode = mux; reqWrite = wr; reqSize = sz; reqAddr = a; reqWData = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (bad) begin
      check("R6 csN on refused request", {26'd0, csN}, {26'd0, 6'h3F});
      check("R6 tsN on refused request", {31'd0, tsN}, 32'd1);
      check("R6 busy on refused request", {31'd0, busy}, 32'd0);
      return;
    end
    // address phase
    check("R4 tsN address phase", {31'd0, tsN}, 32'd0);
    check("R4 ale address phase", {31'd0, ale}, 32'd1);
    check("R3 csN", {26'd0, csN}, {26'd0, ~(6'd1 << win)});
    check("R2 rdWr", {31'd0, rdWr}, {31'd0, !wr});
    check("R2 oeN address phase", {31'd0, oeN}, 32'd1);
    check("R5 tsiz", {30'd0, tsiz}, (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd0);
    check("R5 tbstN", {31'd0, tbstN}, 32'd1);
    check("R11 beN", {28'd0, beN}, {28'd0, ~sel});
    if (mux) begin
      check("R7 busDOut address", busDOut, a);
      check("R7 busDOe address", {28'd0, busDOe}, 32'hF);
    end else begin
      check("R9 busAddr address phase", busAddr, a);
      check("R9 busDOe address phase", {28'd0, busDOe}, {28'd0, dl & {4{wr}}});
      if (wr) check("R9 write data address phase", busDOut & {{8{dl[3]}},{8{dl[2]}},{8{dl[1]}},{8{dl[0]}}},
                    rep & {{8{dl[3]}},{8{dl[2]}},{8{dl[1]}},{8{dl[0]}}});
    end
    @(negedge clk);
    // data phase
    for (int w = 0; w <= waits; w++) begin
      check("R4 tsN data phase", {31'd0, tsN}, 32'd1);
      check("R4 ale data phase", {31'd0, ale}, 32'd0);
      check("R10 busy while waiting", {31'd0, busy}, 32'd1);
      check("R3 csN held", {26'd0, csN}, {26'd0, ~(6'd1 << win)});
      check("R2 oeN data phase", {31'd0, oeN}, {31'd0, wr});
      expOe  = mux ? (~dl | (dl & {4{wr}})) : (dl & {4{wr}});
      expOut = '0;
      for (int l = 0; l < 4; l++)
        expOut[8*l +: 8] = dl[l] ? rep[8*l +: 8] : a[8*l +: 8];
      lm = {{8{expOe[3]}},{8{expOe[2]}},{8{expOe[1]}},{8{expOe[0]}}};
      if (mux) begin
        check("R8 busDOe data phase", {28'd0, busDOe}, {28'd0, expOe});
        check("R8 busDOut data phase", busDOut & lm, expOut & lm);
      end else begin
        check("R9 busAddr data phase", busAddr, a);
        check("R9 busDOe data phase", {28'd0, busDOe}, {28'd0, expOe});
        check("R11 busDOut data phase", busDOut & lm, expOut & lm);
      end
      taN    = (w == waits) ? 1'b0 : 1'b1;
      busDIn = (w == waits) ? rd : 32'hFFFF_FFFF;
      @(negedge clk);
    end
    taN = 1'b1;
    busDIn = '0;
    check("R10 busy after ack", {31'd0, busy}, 32'd0);
    check("R1 csN after cycle", {26'd0, csN}, {26'd0, 6'h3F});
    check("R1 beN after cycle", {28'd0, beN}, 32'hF);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; muxMode = 1'b1; reqValid = 1'b0; reqWrite = 1'b0; reqSize = '0;
    reqAddr = '0; reqWData = '0; busDIn = '0; taN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 csN reset", {26'd0, csN}, {26'd0, 6'h3F});
    check("R1 tsN reset", {31'd0, tsN}, 32'd1);
    check("R1 ale reset", {31'd0, ale}, 32'd0);
    check("R1 oeN reset", {31'd0, oeN}, 32'd1);
    check("R1 rdWr reset", {31'd0, rdWr}, 32'd1);
    check("R1 busDOe reset", {28'd0, busDOe}, 32'd0);
    check("R1 busy reset", {31'd0, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // shared mode, each port width
    txn(1, 1, 2'd2, 32'h0000_1234, 32'hDEAD_BEEF, 32'd0, 0);
    txn(1, 0, 2'd2, 32'h4000_0010, 32'd0, 32'hCAFE_F00D, 2);
    txn(1, 1, 2'd1, 32'h1000_0102, 32'h0000_ABCD, 32'd0, 1);
    txn(1, 0, 2'd0, 32'h2000_0003, 32'd0, 32'h5A00_0000, 0);
    txn(1, 1, 2'd0, 32'h2012_3457, 32'h0000_00C3, 32'd0, 0);
    txn(1, 0, 2'd1, 32'h3000_0006, 32'd0, 32'h1357_2468, 1); // R3 priority: lowest index window 5 only
    txn(1, 0, 2'd1, 32'h2000_0006, 32'd0, 32'h1357_2468, 0); // R3 priority: 2 beats 5, but 8-bit port -> R6
    // separate mode
    txn(0, 1, 2'd0, 32'h0000_0007, 32'h0000_0077, 32'd0, 0);
    txn(0, 0, 2'd0, 32'h0000_0005, 32'd0, 32'h1122_3344, 1);
    txn(0, 0, 2'd1, 32'h4000_0002, 32'd0, 32'h8899_AABB, 0);
    txn(0, 1, 2'd0, 32'h5000_0001, 32'h0000_0042, 32'd0, 3);
    // refused requests then a good one
    txn(1, 0, 2'd0, 32'h8000_0000, 32'd0, 32'd0, 0);
    txn(0, 1, 2'd2, 32'h1000_0000, 32'h0, 32'd0, 0);
    txn(1, 1, 2'd3, 32'h0000_0000, 32'h0, 32'd0, 0);
    txn(1, 0, 2'd0, 32'h0000_0002, 32'd0, 32'h00EE_0000, 0);
    repeat (2) @(negedge clk);
    check("R10 all responses seen", expQ.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule